// File: doc/BRIEF.md
# Byte-Wide Programmable Read-Only Memory Mode Emulator

This block is a synthesizable stand-in for a byte-wide, one-time or light-erasable programmable read-only memory with a 16-bit address. It lets a memory controller or a device programmer be exercised on an FPGA or in simulation without a real part. Each clock, the block looks at the chip-select level, a two-bit code for the output-enable / program-voltage pin, a flag marking a high voltage on address line 9, and the address. From these it picks one operating mode. It then serves the stored byte, serves an identifier byte, floats the bus, or takes part in a program cycle.

The bidirectional data bus is split into an input word, an output word and an output-drive flag. All outputs are registered, so any change on the inputs shows up on the outputs one clock later. Programming is one-way: a program cycle can only turn ones into zeros. Only the `erase` input, which stands in for light erasure, brings cells back to ones.

The physical storage holds 2^STORE_AW bytes. The default is 256 bytes, so that elaboration stays small. The address bits above STORE_AW alias onto this storage.

Top module: `eprom_mode_emu`

## Requirements
- R1: While reset is held and after it is released, `dq_oe` is 0, `dq_out` is 00h, and both `lvl_err` and `proto_err` are 0. Every stored byte reads FFh until it is programmed.
- R2: Read and verify: with `ce_n`=0, `oe_lvl`=00 (logic low) and `a9_hv`=0, the outputs after the next clock edge show `dq_oe`=1 and `dq_out` equal to the byte stored at `addr[STORE_AW-1:0]`. Address bits at and above STORE_AW are ignored.
- R3: Output disable and standby: when `oe_lvl`=01 (logic high), or when `ce_n`=1 with `oe_lvl` not 10, the outputs after the next clock edge show `dq_oe`=0 and `dq_out`=00h. Whenever `dq_oe` is 0, `dq_out` is 00h.
- R4: Program: a clock with `ce_n`=0 and `oe_lvl`=10 (program voltage) latches `addr` and `dq_in`. The bus is not driven in this mode. A following clock with `ce_n`=1 and `oe_lvl` still 10 replaces the latched location with (old AND latched data). Later changes on `dq_in` do not affect the value written.
- R5: Program inhibit: `ce_n`=1 with `oe_lvl`=10 never starts a write by itself. If `oe_lvl` leaves 10 before `ce_n` rises, the pending cycle writes nothing.
- R6: Identifier read: with `ce_n`=0, `oe_lvl`=00, `a9_hv`=1, and every address bit other than bits 0 and 9 at zero, the block drives 01h when `addr[0]`=0 and 91h when `addr[0]`=1. Both bytes have odd parity, with bit 7 as the parity bit. Codes with even parity are rejected at elaboration.
- R7: Identifier read with any address bit other than bits 0 and 9 set drives 00h with `dq_oe`=1 and raises `proto_err` for that cycle.
- R8: `oe_lvl`=11 is an illegal level. It raises `lvl_err` after the next clock edge, leaves the bus undriven, and neither writes nor completes a pending program cycle, whatever the value of `ce_n`.
- R9: A clock edge with `erase`=1 sets every stored byte to FFh. If a write is due on the same edge, the erase takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address; bit 0 selects the identifier byte |
| ce_n | input | 1 | Active-low chip select |
| oe_lvl | input | 2 | Output-enable pin level: 00 low, 01 high, 10 program voltage, 11 illegal |
| a9_hv | input | 1 | High voltage present on address line 9 |
| dq_in | input | DATA_W | Data presented on the bus by the host |
| erase | input | 1 | Sets all stored bytes to ones |
| dq_out | output | DATA_W | Data driven by the block, 00h when not driving |
| dq_oe | output | 1 | Block drives the data bus |
| lvl_err | output | 1 | Illegal output-enable level seen |
| proto_err | output | 1 | Identifier read with stray address bits set |

## Verification
Random reads are mixed with program cycles whose data overlap earlier programs at the same few low addresses. A stored value therefore only matches the bench model if writes are combined by AND, which separates a correct write from a plain overwrite. The random addresses carry random upper bits, which exposes any use of address bits beyond the storage width. Aborted program cycles take two forms: the level leaves program voltage before chip select rises, or an illegal level is applied. Both show whether the write is gated by the level at the closing edge or only by the edge of chip select. Identifier reads are tried with A0 alone, with A9 also set, and with one stray bit set, which tells the clean address decode apart from the violation path.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;

   // Encoding of the output-enable / program-voltage pin level.
   localparam logic [1:0] LVL_LOW  = 2'b00;
   localparam logic [1:0] LVL_HIGH = 2'b01;
   localparam logic [1:0] LVL_VPP  = 2'b10;
   localparam logic [1:0] LVL_BAD  = 2'b11;

   typedef enum logic [2:0] {
      M_STANDBY,
      M_INHIBIT,
      M_OUTDIS,
      M_READ,
      M_PROGRAM,
      M_IDREAD,
      M_ILLEGAL
   } emu_mode_e;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
   import eprom_emu_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              ce_n,
   input  logic [1:0]        oe_lvl,
   input  logic              a9_hv,
   input  logic [ADDR_W-1:0] addr,
   output emu_mode_e         mode,
   output logic              stray_addr
);

   // Bits 0 and 9 are free during an identifier read; all others must be low.
   localparam logic [ADDR_W-1:0] ID_FREE = (ADDR_W'(1) << 9) | ADDR_W'(1);

   assign stray_addr = |(addr & ~ID_FREE);

   always_comb begin
      if (oe_lvl == LVL_BAD)        mode = M_ILLEGAL;
      else if (ce_n)                mode = (oe_lvl == LVL_VPP) ? M_INHIBIT : M_STANDBY;
      else if (oe_lvl == LVL_VPP)   mode = M_PROGRAM;
      else if (oe_lvl == LVL_HIGH)  mode = M_OUTDIS;
      else if (a9_hv)               mode = M_IDREAD;
      else                          mode = M_READ;
   end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
   parameter int STORE_AW = 8,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                erase,
   input  logic                wr_en,
   input  logic [STORE_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [STORE_AW-1:0] rd_addr,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int DEPTH = 1 << STORE_AW;

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[w] <= '1;
         else if (erase)
            cells[w] <= '1;
         else if (wr_en && (wr_addr == STORE_AW'(w)))
            cells[w] <= cells[w] & wr_data;   // bits only ever fall
      end
   end

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
   import eprom_emu_pkg::*;
#(
   parameter int STORE_AW = 8,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  emu_mode_e           mode,
   input  logic [STORE_AW-1:0] addr_lo,
   input  logic [DATA_W-1:0]   dq_in,
   output logic                wr_en,
   output logic [STORE_AW-1:0] wr_addr,
   output logic [DATA_W-1:0]   wr_data
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         wr_addr <= '0;
         wr_data <= '1;
      end else begin
         armed_q <= (mode == M_PROGRAM);
         if (mode == M_PROGRAM) begin
            wr_addr <= addr_lo;
            wr_data <= dq_in;
         end
      end
   end

   // The cycle closes when chip select rises with program voltage still applied.
   assign wr_en = armed_q && (mode == M_INHIBIT);

endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
   import eprom_emu_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter logic [7:0]  MFR_ID = 8'h01,
   parameter logic [7:0]  DEV_ID = 8'h91
) (
   input  logic              clk,
   input  logic              rst_n,
   input  emu_mode_e         mode,
   input  logic              stray_addr,
   input  logic              a0,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              lvl_err,
   output logic              proto_err
);

   logic [DATA_W-1:0] id_byte;
   logic [DATA_W-1:0] nxt_out;
   logic              nxt_oe;

   assign id_byte = a0 ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);

   always_comb begin
      nxt_oe  = 1'b0;
      nxt_out = '0;
      case (mode)
         M_READ:   begin nxt_oe = 1'b1; nxt_out = rd_data; end
         M_IDREAD: begin nxt_oe = 1'b1; nxt_out = stray_addr ? '0 : id_byte; end
         default:  begin nxt_oe = 1'b0; nxt_out = '0; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_out    <= '0;
         dq_oe     <= 1'b0;
         lvl_err   <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         dq_out    <= nxt_out;
         dq_oe     <= nxt_oe;
         lvl_err   <= (mode == M_ILLEGAL);
         proto_err <= (mode == M_IDREAD) && stray_addr;
      end
   end

endmodule

// File: rtl/eprom_mode_emu.sv
module eprom_mode_emu
   import eprom_emu_pkg::*;
#(
   parameter int         ADDR_W   = 16,
   parameter int         DATA_W   = 8,
   parameter int         STORE_AW = 8,
   parameter logic [7:0] MFR_ID   = 8'h01,
   parameter logic [7:0] DEV_ID   = 8'h91
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic [1:0]        oe_lvl,
   input  logic              a9_hv,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              erase,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              lvl_err,
   output logic              proto_err
);

   // Elaboration-time parameter checks.
   if (ADDR_W < 10) begin : g_bad_addr_w
      $error("ADDR_W must reach address line 9");
   end
   if (STORE_AW < 1 || STORE_AW > ADDR_W) begin : g_bad_store_aw
      $error("STORE_AW must lie in 1..ADDR_W");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must hold an identifier byte");
   end
   if (!(^MFR_ID) || !(^DEV_ID)) begin : g_bad_parity   // R6
      $error("identifier codes need odd parity");
   end

   emu_mode_e             mode;
   logic                  stray_addr;
   logic                  wr_en;
   logic [STORE_AW-1:0]   wr_addr;
   logic [DATA_W-1:0]     wr_data;
   logic [DATA_W-1:0]     rd_data;

   eprom_mode_dec #(.ADDR_W(ADDR_W)) i_dec (
      .ce_n       (ce_n),
      .oe_lvl     (oe_lvl),
      .a9_hv      (a9_hv),
      .addr       (addr),
      .mode       (mode),
      .stray_addr (stray_addr)
   );

   eprom_prog_seq #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .addr_lo (addr[STORE_AW-1:0]),
      .dq_in   (dq_in),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   eprom_cell_array #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) i_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase   (erase),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (addr[STORE_AW-1:0]),
      .rd_data (rd_data)
   );

   eprom_out_stage #(.DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .stray_addr (stray_addr),
      .a0         (addr[0]),
      .rd_data    (rd_data),
      .dq_out     (dq_out),
      .dq_oe      (dq_oe),
      .lvl_err    (lvl_err),
      .proto_err  (proto_err)
   );

endmodule

// File: rtl/eprom_mode_emu_chk.sv
module eprom_mode_emu_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ce_n,
   input logic [1:0]        oe_lvl,
   input logic              a9_hv,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe,
   input logic              lvl_err,
   input logic              proto_err
);

   localparam logic [ADDR_W-1:0] FREE_BITS = (ADDR_W'(1) << 9) | ADDR_W'(1);

   logic id_clean, id_stray;
   assign id_clean = !ce_n && (oe_lvl == 2'b00) && a9_hv && ((addr & ~FREE_BITS) == '0);
   assign id_stray = !ce_n && (oe_lvl == 2'b00) && a9_hv && ((addr & ~FREE_BITS) != '0);

   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !dq_oe && !lvl_err && !proto_err)
      else $error("reset outputs not quiet");

   p_undriven_zero_r3: assert property (@(posedge clk) disable iff (!rst_n) !dq_oe |-> dq_out == '0)
      else $error("undriven bus carries data");

   p_standby_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_lvl == 2'b01) |=> !dq_oe)
      else $error("bus driven in standby or output disable");

   p_prog_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_lvl == 2'b10) |=> !dq_oe)
      else $error("bus driven during program");

   p_id_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
      id_clean |=> dq_oe && (^dq_out[7:0]) && !proto_err)
      else $error("identifier byte parity or drive wrong");

   p_id_stray_r7: assert property (@(posedge clk) disable iff (!rst_n)
      id_stray |=> dq_oe && proto_err && dq_out == '0)
      else $error("stray identifier address not flagged");

   p_bad_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_lvl == 2'b11) |=> lvl_err && !dq_oe)
      else $error("illegal level not flagged");

endmodule

bind eprom_mode_emu eprom_mode_emu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .ce_n      (ce_n),
   .oe_lvl    (oe_lvl),
   .a9_hv     (a9_hv),
   .dq_out    (dq_out),
   .dq_oe     (dq_oe),
   .lvl_err   (lvl_err),
   .proto_err (proto_err)
);

// File: tb/test_eprom_mode_emu.sv
module test_eprom_mode_emu;

   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int SAW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          ce_n;
   logic [1:0]    oe_lvl;
   logic          a9_hv;
   logic [DW-1:0] dq_in;
   logic          erase;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic          lvl_err;
   logic          proto_err;

   always #10 clk = ~clk;   // 50 MHz

   eprom_mode_emu i_eprom_mode_emu (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_lvl(oe_lvl),
      .a9_hv(a9_hv), .dq_in(dq_in), .erase(erase), .dq_out(dq_out),
      .dq_oe(dq_oe), .lvl_err(lvl_err), .proto_err(proto_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;
   logic [DW-1:0] mdl [1 << SAW];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // Apply inputs after a falling edge; return after the next falling edge,
   // so the registered outputs reflect the inputs just applied.
   task automatic apply(logic c, logic [1:0] l, logic hv, logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      ce_n = c; oe_lvl = l; a9_hv = hv; addr = a; dq_in = d;
      @(negedge clk);
   endtask

   function automatic logic [DW-1:0] id_exp(logic [AW-1:0] a);
      logic [AW-1:0] free = (AW'(1) << 9) | AW'(1);
      if ((a & ~free) != '0) return 8'h00;
      return a[0] ? 8'h91 : 8'h01;
   endfunction

   task automatic do_read(logic [AW-1:0] a);
      apply(1'b0, 2'b00, 1'b0, a, DW'($urandom));
      check("R2 read drive", dq_oe, 1);
      check("R2 read data", dq_out, mdl[a[SAW-1:0]]);
      check("R2 no flags", {lvl_err, proto_err}, 0);
   endtask

   task automatic do_prog(logic [AW-1:0] a, logic [DW-1:0] d);
      apply(1'b0, 2'b10, 1'b0, a, d);
      check("R4 no drive in program", dq_oe, 0);
      apply(1'b1, 2'b10, 1'b0, AW'($urandom), DW'($urandom));  // late bus changes ignored
      check("R5 inhibit floats", dq_oe, 0);
      mdl[a[SAW-1:0]] = mdl[a[SAW-1:0]] & d;
   endtask

   task automatic do_id(logic [AW-1:0] a);
      logic [DW-1:0] e = id_exp(a);
      apply(1'b0, 2'b00, 1'b1, a, DW'($urandom));
      check("R6 id drive", dq_oe, 1);
      check("R6 id byte", dq_out, e);
      check("R7 proto flag", proto_err, (e == 8'h00) ? 1 : 0);
      if (e != 8'h00) check("R6 id odd parity", ^dq_out, 1);
   endtask

   task automatic do_erase();
      @(negedge clk);
      ce_n = 1'b1; oe_lvl = 2'b01; erase = 1'b1;
      @(negedge clk);
      erase = 1'b0;
      for (int i = 0; i < (1 << SAW); i++) mdl[i] = '1;
   endtask

   initial begin
      #(20 * 150000);
      if (!ended) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < (1 << SAW); i++) mdl[i] = '1;
      rst_n = 1'b0; ce_n = 1'b1; oe_lvl = 2'b01; a9_hv = 1'b0;
      addr = '0; dq_in = '0; erase = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset drive", dq_oe, 0);
      check("R1 reset data", dq_out, 0);
      check("R1 reset flags", {lvl_err, proto_err}, 0);
      rst_n = 1'b1;
      do_read(16'h0000);
      do_read(16'hFF37);
      check("R1 fresh byte", dq_out, 8'hFF);

      // Standby and output disable.
      apply(1'b1, 2'b00, 1'b0, 16'h0012, 8'h00);
      check("R3 standby float", {dq_oe, dq_out}, 0);
      apply(1'b0, 2'b01, 1'b0, 16'h0012, 8'h00);
      check("R3 output disable float", {dq_oe, dq_out}, 0);

      // Programming clears bits only, with aliasing of upper address bits.
      do_prog(16'h0005, 8'hF0);
      do_prog(16'hA305, 8'h3C);
      do_read(16'h0005);
      check("R4 and-combined", dq_out, 8'h30);

      // Inhibit alone writes nothing.
      apply(1'b1, 2'b10, 1'b0, 16'h0006, 8'h00);
      apply(1'b1, 2'b01, 1'b0, 16'h0006, 8'h00);
      do_read(16'h0006);
      check("R5 inhibit alone", dq_out, 8'hFF);

      // Aborted cycle: level leaves program voltage before chip select rises.
      apply(1'b0, 2'b10, 1'b0, 16'h0007, 8'h00);
      apply(1'b0, 2'b01, 1'b0, 16'h0007, 8'h00);
      apply(1'b1, 2'b01, 1'b0, 16'h0007, 8'h00);
      do_read(16'h0007);
      check("R5 aborted cycle", dq_out, 8'hFF);

      // Illegal level.
      apply(1'b0, 2'b10, 1'b0, 16'h0008, 8'h00);
      apply(1'b1, 2'b11, 1'b0, 16'h0008, 8'h00);
      check("R8 lvl_err", lvl_err, 1);
      check("R8 no drive", dq_oe, 0);
      apply(1'b0, 2'b11, 1'b0, 16'h0008, 8'h00);
      check("R8 lvl_err ce low", {lvl_err, dq_oe}, 2'b10);
      do_read(16'h0008);
      check("R8 no write", dq_out, 8'hFF);

      // Identifier reads.
      do_id(16'h0000);
      do_id(16'h0001);
      do_id(16'h0201);
      do_id(16'h0004);
      do_id(16'h8001);

      // Erase wins over a write on the same edge.
      apply(1'b0, 2'b10, 1'b0, 16'h0009, 8'h00);
      @(negedge clk);
      ce_n = 1'b1; erase = 1'b1;
      @(negedge clk);
      erase = 1'b0;
      for (int i = 0; i < (1 << SAW); i++) mdl[i] = '1;
      do_read(16'h0009);
      check("R9 erase beats write", dq_out, 8'hFF);
      do_read(16'h0005);
      check("R9 erase restores ones", dq_out, 8'hFF);

      // Constrained random mix.
      for (int n = 0; n < 600; n++) begin
         int op = int'($urandom % 10);
         logic [AW-1:0] a = {AW'($urandom)} & 16'hFF00 | AW'($urandom % 16);
         case (op)
            0, 1, 2, 3: do_read(a);
            4, 5, 6:    do_prog(a, DW'($urandom) | DW'($urandom));
            7:          do_id(($urandom % 2) ? AW'($urandom % 2) : AW'($urandom));
            8: begin
               apply(1'b1, 2'($urandom % 2), 1'b0, a, DW'($urandom));
               check("R3 random standby", {dq_oe, dq_out}, 0);
            end
            default: if ($urandom % 8 == 0) do_erase();
                     else begin
                        apply(1'($urandom), 2'b11, 1'b0, a, DW'($urandom));
                        check("R8 random illegal", {lvl_err, dq_oe}, 2'b10);
                     end
         endcase
      end
      report();
   end

endmodule